// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that talks to external PHYs over a two-wire serial link: a clock output (MDC) and a shared bidirectional data line (MDIO). It speaks both the short Clause 22 framing and the extended Clause 45 framing. A mode bit in the configuration register selects the framing.

Software drives the block through a simple valid/ready register port. It first programs the configuration register with the clock divider, the framing mode and the preamble enable. It then loads the write-data register and writes the command register, and that command write starts a frame. The block generates MDC, optionally sends a 32-bit all-ones preamble, and shifts the frame out. On a read it releases MDIO at the turnaround and captures the 16 data bits that the PHY returns. Completion is polled through pending flags in the two data registers. A separate valid flag in the read-data register tells whether a read produced data.

A Clause 45 register access takes two frames. The first is an address frame that carries the 16-bit register address from the write-data register. The second is a write or read frame that names the same device.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: Configuration register (offset 0) fields: bits [7:0] set the MDC half-period, bit 8 selects Clause 45 (1) or Clause 22 (0), and bit 9 enables the preamble. With the preamble enabled, each frame is preceded by 32 ones, so 64 MDC rising edges occur in total. Without it the frame alone gives 32 rising edges.
- R3: Clause 22 write (command op 0): the wire carries start 01, op 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16 data bits of the write-data register (offset 1, bits [15:0]). All fields are sent MSB first.
- R4: Clause 22 read (command op 1): the wire carries start 01, op 10, PHY address and register address. The master releases MDIO from the first turnaround bit to the end of the frame. The 16 bits sampled afterwards land in the read-data register (offset 2, bits [15:0]), and its valid bit (bit 17) is set.
- R5: Clause 45 address frame (command op 0 in Clause 45 mode): start 00, op 00, PHY address, device address, turnaround 10 and the 16-bit register address taken from the write-data register.
- R6: Clause 45 write (op 1) sends start 00 and op 01 with the write data. Clause 45 read (op 3) sends start 00 and op 11, and captures the returned data as in R4.
- R7: Command register (offset 3) fields: register/device address in [4:0], PHY address in [12:8], op code in [17:16]. An accepted write or address command sets the write-data pending flag (offset 1, bit 16), and a read command sets the read-data pending flag (offset 2, bit 16). The flag reads back set from the cycle after the command write and clears when the frame ends.
- R8: A command written while either pending flag is set is ignored. So is an op code with no meaning in the current mode: codes 2 and 3 in Clause 22, code 2 in Clause 45. An ignored command starts no frame and sets no flag.
- R9: If the PHY does not drive the second turnaround bit low on a read, the valid flag stays clear when the frame completes. The valid flag is also clear while a read is pending.
- R10: The MDC period is twice the half-period field, in system clocks, with a field value of 0 treated as 1. MDIO changes only right after an MDC falling edge, and MDC stays low when no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always ready) |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 2 | Register offset (0 config, 1 write data, 2 read data, 3 command) |
| req_wdata | input | 32 | Register write data |
| resp_valid | output | 1 | Read response valid, one cycle after the request |
| resp_data | output | 32 | Read response data |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The frame engine is exercised with every valid opcode in both framings: Clause 22 write and read, and Clause 45 address, write and read. It also runs with the preamble on and off. Comparing the captured wire bits against frames assembled from the requirements separates the start and op encodings of the two modes. It also checks the source of the data field (write data or register address) and the ordering of the address fields. Reads are tried with a PHY that answers correctly and with one that leaves the turnaround high, which tells data capture apart from the valid decision. Commands issued while busy, commands with undefined op codes and a changed divider value show that stray commands start nothing and that the MDC period follows the divider field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W     = 8;
    localparam int DATA_W    = 16;
    localparam int FIELD_W   = 5;
    localparam int FRAME_LEN = 32;
    localparam int PRE_LEN   = 32;
    localparam int SHIFT_LEN = FRAME_LEN + PRE_LEN;
    localparam int IDX_W     = $clog2(SHIFT_LEN + 1);

    localparam logic [1:0] OFS_CFG  = 2'd0;
    localparam logic [1:0] OFS_WDAT = 2'd1;
    localparam logic [1:0] OFS_RDAT = 2'd2;
    localparam logic [1:0] OFS_CMD  = 2'd3;

    typedef struct packed {
        logic       ok;
        logic       rd;
        logic [1:0] st;
        logic [1:0] op;
    } op_dec_t;

    typedef struct packed {
        logic [1:0]         st;
        logic [1:0]         op;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] ra;
        logic [1:0]         ta;
        logic [DATA_W-1:0]  data;
    } frame_t;

    // Map a command op code to wire start/op bits for the selected framing.
    function automatic op_dec_t decode_op(input logic c45, input logic [1:0] code);
        op_dec_t d;
        d = '0;
        if (c45) begin
            d.st = 2'b00;
            case (code)
                2'd0: begin d.ok = 1'b1; d.op = 2'b00; end
                2'd1: begin d.ok = 1'b1; d.op = 2'b01; end
                2'd3: begin d.ok = 1'b1; d.op = 2'b11; d.rd = 1'b1; end
                default: d.ok = 1'b0;
            endcase
        end else begin
            d.st = 2'b01;
            case (code)
                2'd0: begin d.ok = 1'b1; d.op = 2'b01; end
                2'd1: begin d.ok = 1'b1; d.op = 2'b10; d.rd = 1'b1; end
                default: d.ok = 1'b0;
            endcase
        end
        return d;
    endfunction

    function automatic frame_t build_frame(input op_dec_t d,
                                           input logic [FIELD_W-1:0] phy,
                                           input logic [FIELD_W-1:0] ra,
                                           input logic [DATA_W-1:0] data);
        frame_t f;
        f.st   = d.st;
        f.op   = d.op;
        f.phy  = phy;
        f.ra   = ra;
        f.ta   = d.rd ? 2'b11 : 2'b10;
        f.data = d.rd ? '1 : data;
        return f;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = mdio_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             tick;

    assign lim  = (half == '0) ? DIV_W'(1) : half;
    assign tick = (cnt == lim - DIV_W'(1));
    assign rise = en && tick && !mdc;
    assign fall = en && tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R10: the clock parks low whenever no frame runs
    assert_mdc_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pre_en,
    input  logic              is_read,
    input  frame_t            frame,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok
);
    localparam logic [IDX_W-1:0] PRE_IDX   = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] TA1_IDX   = IDX_W'(2 + 2 + 2*FIELD_W);
    localparam logic [IDX_W-1:0] TA2_IDX   = TA1_IDX + IDX_W'(1);
    localparam logic [IDX_W-1:0] DATA_IDX  = TA1_IDX + IDX_W'(2);

    logic [SHIFT_LEN-1:0] shreg;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     last;
    logic                 pre_q;
    logic                 rd_q;
    logic [DATA_W-1:0]    cap;
    logic                 ta_ok;
    logic [IDX_W-1:0]     fi;
    logic                 in_frame;

    assign in_frame = !pre_q || (idx >= PRE_IDX);
    assign fi       = pre_q ? idx - PRE_IDX : idx;
    assign mdio_o   = busy ? shreg[SHIFT_LEN-1] : 1'b1;
    assign mdio_oe  = busy && !(rd_q && in_frame && fi >= TA1_IDX);
    assign rd_data  = cap;
    assign rd_ok    = ta_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            shreg <= '0;
            idx   <= '0;
            last  <= '0;
            pre_q <= 1'b0;
            rd_q  <= 1'b0;
            cap   <= '0;
            ta_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                pre_q <= pre_en;
                rd_q  <= is_read;
                idx   <= '0;
                ta_ok <= 1'b0;
                cap   <= '0;
                if (pre_en) begin
                    shreg <= {{PRE_LEN{1'b1}}, frame};
                    last  <= IDX_W'(SHIFT_LEN - 1);
                end else begin
                    shreg <= {frame, {PRE_LEN{1'b0}}};
                    last  <= IDX_W'(FRAME_LEN - 1);
                end
            end else if (busy) begin
                if (rise && rd_q && in_frame) begin
                    if (fi == TA2_IDX)
                        ta_ok <= !mdio_i;
                    if (fi >= DATA_IDX)
                        cap <= {cap[DATA_W-2:0], mdio_i};
                end
                if (fall) begin
                    if (idx == last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        shreg <= {shreg[SHIFT_LEN-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R10: the driven bit moves only after a falling MDC edge
    assert_mdio_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(fall)) |-> $stable(mdio_o));

    // R8: the register block never launches a frame over a running one
    assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R4: the line stays released for the whole tail of a read frame
    assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_q && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]   cfg_half;
    logic               cfg_c45;
    logic               cfg_pre;
    logic [DATA_W-1:0]  wdat;
    logic               wpend;
    logic [DATA_W-1:0]  rdat;
    logic               rpend;
    logic               rvalid;

    logic               wr_en;
    logic               rd_en;
    logic               cmd_wr;
    logic               start;
    op_dec_t            dec;
    frame_t             frame;
    logic               eng_busy;
    logic               eng_done;
    logic [DATA_W-1:0]  eng_rdata;
    logic               eng_rok;
    logic               mdc_rise;
    logic               mdc_fall;

    assign req_ready = 1'b1;
    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign cmd_wr    = wr_en && (req_addr == OFS_CMD);
    assign dec       = decode_op(cfg_c45, req_wdata[17:16]);
    assign start     = cmd_wr && dec.ok && !wpend && !rpend;
    assign frame     = build_frame(dec, req_wdata[12:8], req_wdata[4:0], wdat);

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .en   (eng_busy),
        .half (cfg_half),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_eng u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .pre_en  (cfg_pre),
        .is_read (dec.rd),
        .frame   (frame),
        .rise    (mdc_rise),
        .fall    (mdc_fall),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .done    (eng_done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (eng_rdata),
        .rd_ok   (eng_rok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_half <= '0;
            cfg_c45  <= 1'b0;
            cfg_pre  <= 1'b0;
            wdat     <= '0;
            wpend    <= 1'b0;
            rdat     <= '0;
            rpend    <= 1'b0;
            rvalid   <= 1'b0;
        end else begin
            if (wr_en && req_addr == OFS_CFG) begin
                cfg_half <= req_wdata[DIV_W-1:0];
                cfg_c45  <= req_wdata[8];
                cfg_pre  <= req_wdata[9];
            end
            if (wr_en && req_addr == OFS_WDAT)
                wdat <= req_wdata[DATA_W-1:0];
            if (start) begin
                if (dec.rd) begin
                    rpend  <= 1'b1;
                    rvalid <= 1'b0;
                end else begin
                    wpend <= 1'b1;
                end
            end else if (eng_done) begin
                if (rpend) begin
                    rpend  <= 1'b0;
                    rdat   <= eng_rdata;
                    rvalid <= eng_rok;
                end
                wpend <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= rd_en;
            if (rd_en) begin
                case (req_addr)
                    OFS_CFG:  resp_data <= {22'd0, cfg_pre, cfg_c45, cfg_half};
                    OFS_WDAT: resp_data <= {15'd0, wpend, wdat};
                    OFS_RDAT: resp_data <= {14'd0, rvalid, rpend, rdat};
                    default:  resp_data <= '0;
                endcase
            end
        end
    end

    // R7: at most one kind of frame is outstanding
    assert_one_pending_R7: assert property (@(posedge clk) disable iff (rst)
        !(wpend && rpend));

    // R7: a finishing frame always belongs to an outstanding command
    assert_done_has_pending_R7: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> (wpend || rpend));

    // R9: read data is never flagged valid while its read is still running
    assert_no_valid_while_pending_R9: assert property (@(posedge clk) disable iff (rst)
        rpend |-> !rvalid);

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // PHY model state
    logic        phy_en   = 1'b0;
    logic        phy_val  = 1'b1;
    logic        phy_read = 1'b0;
    logic        phy_bad_ta = 1'b0;
    logic [15:0] phy_data = 16'h0;
    int          phy_pre  = 32;
    logic        cap_bits [0:63];
    int          nbits = 0;
    int          rise_t [0:1];

    always #5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_master dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    always @(posedge mdc) begin
        if (nbits < 64) cap_bits[nbits] = mdio_line;
        if (nbits < 2) rise_t[nbits] = cyc;
        nbits = nbits + 1;
    end

    always @(negedge mdc) begin
        int fi;
        fi = nbits - phy_pre;
        if (phy_read && fi >= 15 && fi <= 31) begin
            phy_en  = 1'b1;
            phy_val = (fi == 15) ? phy_bad_ta : phy_data[31 - fi];
        end else begin
            phy_en  = 1'b0;
            phy_val = 1'b1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = resp_data;
    endtask

    task automatic set_cfg(input logic [7:0] half, input logic c45, input logic pre);
        reg_wr(2'd0, {22'd0, pre, c45, half});
        phy_pre = pre ? 32 : 0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        nbits = 0;
        reg_wr(2'd3, {14'd0, op, 3'd0, phy, 3'd0, ra});
    endtask

    task automatic wait_idle();
        logic [31:0] w, r;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(2'd1, w);
            reg_rd(2'd2, r);
            if (!w[16] && !r[16]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] wire_frame();
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) v[31 - i] = cap_bits[phy_pre + i];
        return v;
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] ra,
                                       input logic [15:0] d);
        return {st, op, phy, ra, 2'b10, d};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(2'd0, v); chk("R1", "cfg after reset", v, 0);
        reg_rd(2'd1, v); chk("R1", "wdata after reset", v, 0);
        reg_rd(2'd2, v); chk("R1", "rdata after reset", v, 0);
        chk("R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        logic        pre_ok;
        set_cfg(8'd2, 1'b0, 1'b1);
        reg_wr(2'd1, 32'h0000_C3A1);
        phy_read = 1'b0;
        send_cmd(2'd0, 5'd9, 5'd22);
        reg_rd(2'd1, v); chk("R7", "write pending set", v[16], 1);
        reg_rd(2'd2, v); chk("R7", "read pending clear on write", v[16], 0);
        wait_idle();
        chk("R2", "rise count with preamble", nbits, 64);
        pre_ok = 1'b1;
        for (int i = 0; i < 32; i++) if (cap_bits[i] !== 1'b1) pre_ok = 1'b0;
        chk("R2", "preamble all ones", pre_ok, 1);
        chk("R3", "c22 write frame", wire_frame(), mk(2'b01, 2'b01, 5'd9, 5'd22, 16'hC3A1));
        reg_rd(2'd1, v); chk("R7", "write pending cleared", v[16], 0);
        chk("R10", "mdc low when idle", mdc, 0);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        set_cfg(8'd2, 1'b0, 1'b1);
        phy_read = 1'b1; phy_bad_ta = 1'b0; phy_data = 16'hA5C3;
        send_cmd(2'd1, 5'd4, 5'd1);
        reg_rd(2'd2, v); chk("R7", "read pending set", v[17:16], 2'b01);
        wait_idle();
        v = wire_frame();
        chk("R4", "c22 read header", v[31:18], mk(2'b01, 2'b10, 5'd4, 5'd1, 16'h0) >> 18);
        reg_rd(2'd2, v); chk("R4", "c22 read data/valid", v, {14'd0, 1'b1, 1'b0, 16'hA5C3});
        phy_read = 1'b0;
    endtask

    task automatic t_c45_addr_write();
        logic [31:0] v;
        set_cfg(8'd2, 1'b1, 1'b1);
        phy_read = 1'b0;
        reg_wr(2'd1, 32'h0000_BEEF);
        send_cmd(2'd0, 5'd3, 5'd5);
        wait_idle();
        chk("R5", "c45 address frame", wire_frame(), mk(2'b00, 2'b00, 5'd3, 5'd5, 16'hBEEF));
        reg_wr(2'd1, 32'h0000_1357);
        send_cmd(2'd1, 5'd3, 5'd5);
        reg_rd(2'd1, v); chk("R7", "c45 write pending set", v[16], 1);
        wait_idle();
        chk("R6", "c45 write frame", wire_frame(), mk(2'b00, 2'b01, 5'd3, 5'd5, 16'h1357));
    endtask

    task automatic t_c45_read();
        logic [31:0] v;
        set_cfg(8'd2, 1'b1, 1'b1);
        phy_read = 1'b1; phy_bad_ta = 1'b0; phy_data = 16'h1234;
        send_cmd(2'd3, 5'd17, 5'd30);
        wait_idle();
        v = wire_frame();
        chk("R6", "c45 read header", v[31:18], mk(2'b00, 2'b11, 5'd17, 5'd30, 16'h0) >> 18);
        reg_rd(2'd2, v); chk("R6", "c45 read data/valid", v, {14'd0, 1'b1, 1'b0, 16'h1234});
        phy_read = 1'b0;
    endtask

    task automatic t_bad_turnaround();
        logic [31:0] v;
        set_cfg(8'd2, 1'b0, 1'b1);
        phy_read = 1'b1; phy_bad_ta = 1'b1; phy_data = 16'h00FF;
        send_cmd(2'd1, 5'd2, 5'd3);
        reg_rd(2'd2, v); chk("R9", "valid clear while pending", v[17:16], 2'b01);
        wait_idle();
        reg_rd(2'd2, v); chk("R9", "valid clear on missing turnaround", v[17:16], 2'b00);
        phy_read = 1'b0; phy_bad_ta = 1'b0;
    endtask

    task automatic t_no_preamble();
        set_cfg(8'd2, 1'b0, 1'b0);
        phy_read = 1'b0;
        reg_wr(2'd1, 32'h0000_0F0F);
        send_cmd(2'd0, 5'd31, 5'd0);
        wait_idle();
        chk("R2", "rise count without preamble", nbits, 32);
        chk("R3", "frame without preamble", wire_frame(), mk(2'b01, 2'b01, 5'd31, 5'd0, 16'h0F0F));
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        set_cfg(8'd2, 1'b0, 1'b1);
        phy_read = 1'b0;
        reg_wr(2'd1, 32'h0000_4444);
        send_cmd(2'd0, 5'd1, 5'd1);
        reg_wr(2'd3, {14'd0, 2'd1, 3'd0, 5'd7, 3'd0, 5'd7});
        reg_rd(2'd2, v); chk("R8", "read cmd while busy not pending", v[16], 0);
        wait_idle();
        repeat (300) @(negedge clk);
        chk("R8", "no second frame after busy cmd", nbits, 64);
        chk("R8", "busy cmd did not alter frame", wire_frame(), mk(2'b01, 2'b01, 5'd1, 5'd1, 16'h4444));
        send_cmd(2'd2, 5'd1, 5'd1);
        reg_rd(2'd1, v); chk("R8", "c22 op2 no write pending", v[16], 0);
        reg_rd(2'd2, v); chk("R8", "c22 op2 no read pending", v[16], 0);
        repeat (100) @(negedge clk);
        chk("R8", "c22 op2 no frame", nbits, 0);
        set_cfg(8'd2, 1'b1, 1'b1);
        send_cmd(2'd2, 5'd1, 5'd1);
        repeat (100) @(negedge clk);
        chk("R8", "c45 op2 no frame", nbits, 0);
        reg_rd(2'd1, v); chk("R8", "c45 op2 no pending", v[16], 0);
    endtask

    task automatic t_divider();
        set_cfg(8'd3, 1'b0, 1'b0);
        phy_read = 1'b0;
        send_cmd(2'd0, 5'd0, 5'd0);
        wait_idle();
        chk("R10", "mdc period half=3", rise_t[1] - rise_t[0], 6);
        set_cfg(8'd0, 1'b0, 1'b0);
        send_cmd(2'd0, 5'd0, 5'd0);
        wait_idle();
        chk("R10", "mdc period half=0", rise_t[1] - rise_t[0], 2);
        chk("R10", "rise count half=0", nbits, 32);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_c45_addr_write();
        t_c45_read();
        t_bad_turnaround();
        t_no_preamble();
        t_ignored();
        t_divider();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule